// File: doc/BRIEF.md
# Stereo Audio Decoder FIFO Interface

This block is the buffering and register front end of a compressed-audio decoder. A host writes encoded bytes one at a time into a byte-wide input queue. The decoder core takes those bytes from a pop port and pushes decoded PCM sample pairs into two 16-bit output queues, one for each channel. The host then collects the samples as one 32-bit word that holds both channels, and can exchange the two halves. The decoding arithmetic is not part of this block. A simple consumer/producer port stands in for the core.

Control, interrupt-enable, interrupt-status, queue-state, fill-count and threshold registers sit on a simple word bus. Each queue raises full, empty and threshold flags. The core can be held off the input queue while a chosen output queue is nearly full, so decoded samples never overrun the host. An error pulse from the core sets a sticky status bit that the host clears by writing a one. Self-clearing control bits flush the queues.

Top module: `adec_fifo_if`

## Requirements
- R1: After reset, all three queues are empty, the control and interrupt-enable registers read 0, `irq` is low, and the state register at 0x14 reads 0x00000226 (input empty bit 1, input almost-empty bit 2, left empty bit 5, right empty bit 9).
- R2: A bus write to 0x04 appends bits 7:0 to the 128-entry input queue. A write while the queue holds 128 bytes is dropped. The fill count reads in bits 7:0 of 0x18, and input-full is bit 0 of the state register.
- R3: `core_in_ok` is high only when decoder enable (control bit 0) is set and the input queue is not empty and no flow-control block applies. `core_in_byte` shows the oldest byte. A cycle with `core_in_pop` and `core_in_ok` both high removes it, so bytes leave in write order.
- R4: With control bit 2 set, `core_in_ok` is low while the left queue is almost full. With control bit 3 set, the same applies for the right queue. With both bits clear, the output fill levels do not gate the core.
- R5: A bus read of 0x08 returns the oldest left sample in bits 31:16 and the oldest right sample in bits 15:0. Control bit 1 exchanges the two halves. The read removes one sample from each queue that is not empty, and an empty queue contributes 0. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R6: Each output queue holds 256 samples. A core push drops the sample of any channel whose queue is full. Register 0x1C shows the low 8 bits of the left count in bits 7:0 and of the right count in bits 23:16. Left-full is state bit 4 and right-full is state bit 8.
- R7: Input almost-empty (bit 2) is set when the input count is at or below the level in bits 6:0 of 0x20. Left almost-full (bit 6) and right almost-full (bit 10) are set when the count is at or above the level in bits 15:8 or bits 23:16 of 0x20. The threshold register reads back what was written.
- R8: A `core_in_err` pulse sets status bit 12 of 0x10, and the bit stays set. Writing 1 to bit 12 clears it. Writing 0 leaves it set. A new error in the same cycle as the clear wins.
- R9: Register 0x10 shows the live queue flags in the state-register positions together with the sticky error bit 12. `irq` is high exactly when some status bit and its enable bit in 0x0C are both set. Only bits 0-2, 4-6, 8-10 and 12 of 0x0C are stored.
- R10: In a control write, bit 4 flushes all three queues, bit 5 the input queue, bit 6 the left queue and bit 7 the right queue. The flush takes effect at the same clock edge. These bits read back as 0. Bits 0-3 and 8-11 of the same write are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| core_in_pop | input | 1 | Core takes the oldest input byte |
| core_in_ok | output | 1 | An input byte is available to the core |
| core_in_byte | output | 8 | Oldest input byte |
| core_out_push | input | 1 | Core delivers a sample pair |
| core_out_left | input | 16 | Left sample |
| core_out_right | input | 16 | Right sample |
| core_in_err | input | 1 | Frame error pulse from the core |
| irq | output | 1 | Interrupt request |

## Verification
Writes, flushes, pushes and pops change state at the clock edge where their strobe is sampled. The flags, `core_in_ok`, `core_in_byte` and `irq` follow from that state through logic alone, so they are due right after that edge. Register reads are registered once, so a read issued at one edge shows its value after that edge. The bench drives every strobe for exactly one cycle from the falling edge and samples at the next falling edge. Each check therefore falls in the cycle after the edge that acted. The expected values come from queue models kept in the bench.

// File: rtl/adec_pkg.sv
package adec_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] A_INDATA = 6'h04;
    localparam logic [ADDR_W-1:0] A_OUTDAT = 6'h08;
    localparam logic [ADDR_W-1:0] A_IEN    = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STS    = 6'h10;
    localparam logic [ADDR_W-1:0] A_STATE  = 6'h14;
    localparam logic [ADDR_W-1:0] A_INCNT  = 6'h18;
    localparam logic [ADDR_W-1:0] A_OUTCNT = 6'h1C;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 6'h20;

    localparam int FLAG_W  = 13;
    localparam int F_ERR   = 12;
    localparam logic [FLAG_W-1:0] IEN_MASK = 13'h1777;

    typedef struct packed {
        logic sel_r;
        logic sel_l;
        logic dma_out;
        logic dma_in;
        logic flow_r;
        logic flow_l;
        logic swap;
        logic dec_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [31:0] w);
        return ctrl_t'({w[11:8], w[3:0]});
    endfunction

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        return {20'd0, c.sel_r, c.sel_l, c.dma_out, c.dma_in, 4'd0,
                c.flow_r, c.flow_l, c.swap, c.dec_en};
    endfunction
endpackage

// File: rtl/adec_fifo.sv
module adec_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign count   = st_q.cnt;
    assign head    = empty ? '0 : mem[st_q.rptr];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok)
                st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
            if (pop_ok)
                st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[st_q.wptr] <= wdata;
    end

    // R2 / R6: a push into a full queue leaves it full, nothing is lost track of
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

    // R3: popping an empty queue keeps it empty
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> (count == '0));

    // R10: a flush empties the queue at that edge
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/adec_regs.sv
module adec_regs
    import adec_pkg::*;
#(
    parameter int IN_LVL_W  = 7,
    parameter int OUT_LVL_W = 8,
    parameter logic [IN_LVL_W-1:0]  IN_LVL_RST  = 7'd16,
    parameter logic [OUT_LVL_W-1:0] OUT_LVL_RST = 8'd192
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic                 err_in,
    input  logic [FLAG_W-1:0]    live_flags,
    output ctrl_t                ctrl,
    output logic [FLAG_W-1:0]    ien,
    output logic [FLAG_W-1:0]    status,
    output logic [IN_LVL_W-1:0]  lvl_in,
    output logic [OUT_LVL_W-1:0] lvl_l,
    output logic [OUT_LVL_W-1:0] lvl_r,
    output logic                 flush_in,
    output logic                 flush_l,
    output logic                 flush_r,
    output logic                 irq
);
    typedef struct packed {
        ctrl_t                ctrl;
        logic [FLAG_W-1:0]    ien;
        logic [IN_LVL_W-1:0]  lvl_in;
        logic [OUT_LVL_W-1:0] lvl_l;
        logic [OUT_LVL_W-1:0] lvl_r;
        logic                 err;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ctrl, err_clr;

    assign wr_ctrl  = wr && (addr == A_CTRL);
    assign err_clr  = wr && (addr == A_STS) && wdata[F_ERR];
    assign flush_in = wr_ctrl && (wdata[4] || wdata[5]);
    assign flush_l  = wr_ctrl && (wdata[4] || wdata[6]);
    assign flush_r  = wr_ctrl && (wdata[4] || wdata[7]);

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) r_d.ctrl = ctrl_from_word(wdata);
        if (wr && addr == A_IEN) r_d.ien = wdata[FLAG_W-1:0] & IEN_MASK;
        if (wr && addr == A_LEVEL) begin
            r_d.lvl_in = wdata[IN_LVL_W-1:0];
            r_d.lvl_l  = wdata[8 +: OUT_LVL_W];
            r_d.lvl_r  = wdata[16 +: OUT_LVL_W];
        end
        if (err_clr) r_d.err = 1'b0;
        if (err_in)  r_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.lvl_in <= IN_LVL_RST;
            r_q.lvl_l  <= OUT_LVL_RST;
            r_q.lvl_r  <= OUT_LVL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl   = r_q.ctrl;
    assign ien    = r_q.ien;
    assign lvl_in = r_q.lvl_in;
    assign lvl_l  = r_q.lvl_l;
    assign lvl_r  = r_q.lvl_r;
    assign status = {r_q.err, live_flags[F_ERR-1:0]};
    assign irq    = |(status & r_q.ien);

    // R8: an error pulse always leaves the sticky bit set
    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> status[F_ERR]);

    // R8: without a write-one the sticky bit holds
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[F_ERR] && !err_clr) |=> status[F_ERR]);

    // R9: with nothing enabled the request stays low
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: rtl/adec_fifo_if.sv
module adec_fifo_if
    import adec_pkg::*;
#(
    parameter int IN_DEPTH  = 128,
    parameter int OUT_DEPTH = 256,
    parameter int BYTE_W    = 8,
    parameter int SAMPLE_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                core_in_pop,
    output logic                core_in_ok,
    output logic [BYTE_W-1:0]   core_in_byte,
    input  logic                core_out_push,
    input  logic [SAMPLE_W-1:0] core_out_left,
    input  logic [SAMPLE_W-1:0] core_out_right,
    input  logic                core_in_err,
    output logic                irq
);
    localparam int ICW = $clog2(IN_DEPTH + 1);
    localparam int OCW = $clog2(OUT_DEPTH + 1);

    typedef struct packed {
        logic [31:0] rdata;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    ctrl_t               ctrl;
    logic [FLAG_W-1:0]   ien, status, flags;
    logic [6:0]          lvl_in;
    logic [7:0]          lvl_l, lvl_r;
    logic                flush_in, flush_l, flush_r;
    logic [ICW-1:0]      in_cnt;
    logic [OCW-1:0]      l_cnt, r_cnt;
    logic                in_full, in_empty, l_full, l_empty, r_full, r_empty;
    logic                in_ae, l_af, r_af;
    logic [SAMPLE_W-1:0] l_head, r_head;
    logic                in_push, in_pop, out_pop;

    assign in_push = bus_wr && (bus_addr == A_INDATA);
    assign out_pop = bus_rd && (bus_addr == A_OUTDAT);
    assign in_pop  = core_in_pop && core_in_ok;

    adec_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .err_in(core_in_err), .live_flags(flags), .ctrl(ctrl), .ien(ien),
        .status(status), .lvl_in(lvl_in), .lvl_l(lvl_l), .lvl_r(lvl_r),
        .flush_in(flush_in), .flush_l(flush_l), .flush_r(flush_r), .irq(irq)
    );

    adec_fifo #(.W(BYTE_W), .DEPTH(IN_DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n), .flush(flush_in), .push(in_push),
        .wdata(bus_wdata[BYTE_W-1:0]), .pop(in_pop), .head(core_in_byte),
        .count(in_cnt), .full(in_full), .empty(in_empty)
    );

    adec_fifo #(.W(SAMPLE_W), .DEPTH(OUT_DEPTH)) u_left_q (
        .clk(clk), .rst_n(rst_n), .flush(flush_l), .push(core_out_push),
        .wdata(core_out_left), .pop(out_pop), .head(l_head),
        .count(l_cnt), .full(l_full), .empty(l_empty)
    );

    adec_fifo #(.W(SAMPLE_W), .DEPTH(OUT_DEPTH)) u_right_q (
        .clk(clk), .rst_n(rst_n), .flush(flush_r), .push(core_out_push),
        .wdata(core_out_right), .pop(out_pop), .head(r_head),
        .count(r_cnt), .full(r_full), .empty(r_empty)
    );

    assign in_ae = (in_cnt <= ICW'(lvl_in));
    assign l_af  = (l_cnt >= OCW'(lvl_l));
    assign r_af  = (r_cnt >= OCW'(lvl_r));
    assign flags = {2'b00, r_af, r_empty, r_full, 1'b0, l_af, l_empty, l_full,
                    1'b0, in_ae, in_empty, in_full};

    assign core_in_ok = ctrl.dec_en && !in_empty
                        && !(ctrl.flow_l && l_af) && !(ctrl.flow_r && r_af);

    always_comb begin
        rd_d = rd_q;
        if (bus_rd) begin
            unique case (bus_addr)
                A_CTRL:   rd_d.rdata = ctrl_to_word(ctrl);
                A_OUTDAT: rd_d.rdata = ctrl.swap ? {r_head, l_head} : {l_head, r_head};
                A_IEN:    rd_d.rdata = 32'(ien);
                A_STS:    rd_d.rdata = 32'(status);
                A_STATE:  rd_d.rdata = 32'(flags);
                A_INCNT:  rd_d.rdata = {24'd0, 8'(in_cnt)};
                A_OUTCNT: rd_d.rdata = {8'd0, 8'(r_cnt), 8'd0, 8'(l_cnt)};
                A_LEVEL:  rd_d.rdata = {8'd0, lvl_r, lvl_l, 1'b0, lvl_in};
                default:  rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R4: a nearly full left queue under flow control holds the core off
    assert_flow_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.flow_l && l_af) |-> !core_in_ok);

    // R4: same for the right queue
    assert_flow_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.flow_r && r_af) |-> !core_in_ok);

    // R3: an accepted pop lowers the input count unless a write refills it
    assert_pop_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop && !in_push && !flush_in) |=> (in_cnt == $past(in_cnt) - 1'b1));
endmodule

// File: tb/adec_fifo_if_tb_top.sv
module adec_fifo_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        core_in_pop = 1'b0, core_in_ok;
    logic [7:0]  core_in_byte;
    logic        core_out_push = 1'b0;
    logic [15:0] core_out_left = '0, core_out_right = '0;
    logic        core_in_err = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [7:0]  in_m[$];
    logic [15:0] l_m[$];
    logic [15:0] r_m[$];
    int          lv_in = 16, lv_l = 192, lv_r = 192;
    logic [31:0] ctrl_m = '0;

    always #10 clk = ~clk;

    adec_fifo_if dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_in_pop(core_in_pop), .core_in_ok(core_in_ok),
        .core_in_byte(core_in_byte), .core_out_push(core_out_push),
        .core_out_left(core_out_left), .core_out_right(core_out_right),
        .core_in_err(core_in_err), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_state();
        logic [31:0] s = '0;
        s[0]  = (in_m.size() == 128);
        s[1]  = (in_m.size() == 0);
        s[2]  = (in_m.size() <= lv_in);
        s[4]  = (l_m.size() == 256);
        s[5]  = (l_m.size() == 0);
        s[6]  = (l_m.size() >= lv_l);
        s[8]  = (r_m.size() == 256);
        s[9]  = (r_m.size() == 0);
        s[10] = (r_m.size() >= lv_r);
        return s;
    endfunction

    function automatic logic [31:0] exp_outcnt();
        logic [7:0] a = 8'(l_m.size());
        logic [7:0] b = 8'(r_m.size());
        return {8'd0, b, 8'd0, a};
    endfunction

    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        if (a == 6'h04 && in_m.size() < 128) in_m.push_back(d[7:0]);
        if (a == 6'h00) begin
            ctrl_m = d & 32'h0F0F;
            if (d[4] || d[5]) in_m.delete();
            if (d[4] || d[6]) l_m.delete();
            if (d[4] || d[7]) r_m.delete();
        end
        if (a == 6'h20) begin
            lv_in = int'(d[6:0]); lv_l = int'(d[15:8]); lv_r = int'(d[23:16]);
        end
    endtask

    task automatic bus_read(logic [5:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(logic [5:0] a, logic [31:0] exp, string req);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic read_out_chk(string req);
        logic [15:0] lv, rv;
        lv = (l_m.size() > 0) ? l_m[0] : 16'd0;
        rv = (r_m.size() > 0) ? r_m[0] : 16'd0;
        rd_chk(6'h08, ctrl_m[1] ? {rv, lv} : {lv, rv}, req);
        if (l_m.size() > 0) void'(l_m.pop_front());
        if (r_m.size() > 0) void'(r_m.pop_front());
    endtask

    task automatic core_push(logic [15:0] lv, logic [15:0] rv);
        core_out_left = lv; core_out_right = rv; core_out_push = 1'b1;
        tick();
        core_out_push = 1'b0;
        if (l_m.size() < 256) l_m.push_back(lv);
        if (r_m.size() < 256) r_m.push_back(rv);
    endtask

    task automatic core_take(string req);
        check({req, " ok"}, 32'(core_in_ok), 32'd1);
        check({req, " byte"}, 32'(core_in_byte), 32'(in_m[0]));
        core_in_pop = 1'b1;
        tick();
        core_in_pop = 1'b0;
        void'(in_m.pop_front());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd_chk(6'h14, 32'h226, "R1 state");
        rd_chk(6'h00, 32'h0, "R1 ctrl");
        rd_chk(6'h0C, 32'h0, "R1 ien");
        rd_chk(6'h18, 32'h0, "R1 incnt");
        check("R1 irq", 32'(irq), 32'd0);

        // R7: thresholds read back
        bus_write(6'h20, {8'd0, 8'd4, 8'd6, 1'b0, 7'd3});
        rd_chk(6'h20, 32'h0004_0603, "R7 level");

        // R2 R3: random bursts into the input queue, drained in order
        for (int round = 0; round < 4; round++) begin
            int n = $urandom_range(1, 12);
            bus_write(6'h00, 32'h0);
            for (int i = 0; i < n; i++) bus_write(6'h04, $urandom());
            rd_chk(6'h18, 32'(in_m.size()), "R2 incnt");
            rd_chk(6'h14, exp_state(), "R7 state input");
            check("R3 disabled", 32'(core_in_ok), 32'd0);
            bus_write(6'h00, 32'h1);
            while (in_m.size() > 0) core_take("R3 pop");
            check("R3 empty", 32'(core_in_ok), 32'd0);
        end

        // R2: overfill, then R10 input flush
        for (int i = 0; i < 131; i++) bus_write(6'h04, 32'(i + 7));
        rd_chk(6'h18, 32'h80, "R2 full count");
        rd_chk(6'h14, exp_state(), "R2 full flag");
        core_take("R3 first after fill");
        bus_write(6'h00, 32'h21);
        rd_chk(6'h18, 32'h0, "R10 input flush");
        rd_chk(6'h00, 32'h1, "R10 ctrl readback");

        // R4: flow control
        for (int i = 0; i < 6; i++) core_push(16'($urandom()), 16'($urandom()));
        bus_write(6'h04, 32'h5A);
        bus_write(6'h04, 32'hA5);
        bus_write(6'h00, 32'h5);
        check("R4 left block", 32'(core_in_ok), 32'd0);
        bus_write(6'h00, 32'h9);
        check("R4 right block", 32'(core_in_ok), 32'd0);
        bus_write(6'h00, 32'h1);
        check("R4 no flow", 32'(core_in_ok), 32'd1);
        read_out_chk("R5 word");
        read_out_chk("R5 word");
        bus_write(6'h00, 32'h5);
        check("R4 left below level", 32'(core_in_ok), 32'd1);
        bus_write(6'h00, 32'h9);
        check("R4 right at level", 32'(core_in_ok), 32'd0);
        bus_write(6'h00, 32'h31);
        while (l_m.size() > 0) read_out_chk("R5 drain");

        // R5: swapped words
        for (int i = 0; i < 5; i++) core_push(16'($urandom()), 16'($urandom()));
        bus_write(6'h00, 32'h3);
        rd_chk(6'h00, 32'h3, "R10 ctrl stored");
        for (int i = 0; i < 5; i++) read_out_chk("R5 swap");
        bus_write(6'h00, 32'h0);

        // R6: overfill the output queues
        for (int i = 0; i < 258; i++) core_push(16'($urandom()), 16'($urandom()));
        rd_chk(6'h1C, exp_outcnt(), "R6 full count");
        rd_chk(6'h14, exp_state(), "R6 full flags");
        read_out_chk("R6 first");
        read_out_chk("R6 second");
        rd_chk(6'h1C, 32'h00FE_00FE, "R6 count");
        bus_write(6'h00, 32'h40);
        rd_chk(6'h1C, 32'h00FE_0000, "R10 left flush");
        read_out_chk("R5 left empty");
        bus_write(6'h00, 32'h80);
        rd_chk(6'h1C, 32'h0, "R10 right flush");
        read_out_chk("R5 both empty");

        // R10: decoder-wide flush
        bus_write(6'h04, 32'h11);
        core_push(16'h1234, 16'h5678);
        bus_write(6'h00, 32'h10);
        rd_chk(6'h18, 32'h0, "R10 all input");
        rd_chk(6'h1C, 32'h0, "R10 all output");

        // R8 R9: sticky error and interrupt
        bus_write(6'h0C, 32'hFFFF);
        rd_chk(6'h0C, 32'h1777, "R9 ien mask");
        bus_write(6'h0C, 32'h1000);
        check("R9 idle irq", 32'(irq), 32'd0);
        core_in_err = 1'b1;
        tick();
        core_in_err = 1'b0;
        check("R8 irq set", 32'(irq), 32'd1);
        rd_chk(6'h10, 32'h1000 | exp_state(), "R9 status");
        bus_write(6'h10, 32'h0);
        rd_chk(6'h10, 32'h1000 | exp_state(), "R8 write zero");
        bus_write(6'h10, 32'h1000);
        rd_chk(6'h10, exp_state(), "R8 cleared");
        check("R8 irq clear", 32'(irq), 32'd0);
        bus_write(6'h0C, 32'h2);
        check("R9 live empty irq", 32'(irq), 32'd1);
        bus_write(6'h04, 32'h77);
        check("R9 live nonempty irq", 32'(irq), 32'd0);
        bus_read(6'h00, d);
        check("R1 ctrl after flush write", d, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule